// File: doc/BRIEF.md
# Delayed Write-Protect Chip-Enable Gate

This block sits between a memory controller's active-low chip enables and up to four static RAMs that are kept alive by a backup cell. When the supply monitor flags a power failure, the gate stops new accesses from reaching the memories. An access already under way is allowed to finish. It is cut off only when its enable goes inactive or when a per-channel timeout, counted in millisecond ticks, runs out. After the supply returns, every output stays inactive until a supervisor flag reports that the recovery interval is over.

A two-bit organisation code selects how the enables reach the outputs: four independent memories, two banks of two, or one bank of four. In the shared organisations, two address pins choose which memory receives the enable. The same two pins act as the third and fourth enable inputs when the memories are independent. The organisation code is captured only while reset is applied and on the cycle the power-fail flag clears. At any other time its value is ignored.

Top module: `wp_ce_gate`

## Requirements
- R1: While reset is applied, and in the first cycle after it, all four outputs `ce_n_o` are high (inactive).
- R2: When the power-fail flag is low and the release flag is high, each output takes the value of its routed enable request. The output changes one clock after the request.
- R3: With organisation code 0, output bit 0 follows `ce1_n_i` and bit 1 follows `ce2_n_i`. Bit 2 follows `a_or_ce3_i` and bit 3 follows `b_or_ce4_i`.
- R4: With organisation code 1, `ce1_n_i` serves bits 0 and 1, and `ce2_n_i` serves bits 2 and 3. Address A = 0 picks the lower bit of each pair and A = 1 picks the upper bit. The unpicked bit stays high.
- R5: With organisation code 2 or 3, `ce1_n_i` serves all four bits. The output whose index equals {B,A} may go low. The other three stay high.
- R6: While the power-fail flag is high or the release flag is low, any output that is high stays high. An output whose request is high becomes high at the next clock.
- R7: An output that is low, and whose request is still low, when protection begins stays low while that request stays low. This lasts until the timeout.
- R8: Once a held output's request goes high, the output goes high. It stays high, even if the request falls again, until the power-fail flag is low and the release flag is high.
- R9: A held output is forced high in the cycle after the LIMIT-th millisecond tick seen while it is held, even if its request is still low.
- R10: The organisation code is loaded from `mode_i` during reset and on the first cycle the power-fail flag is low after being high. Changes at any other time have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail_i | input | 1 | Supply out of tolerance (high = failed) |
| wp_release_i | input | 1 | Recovery interval over; outputs may pass |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| mode_i | input | 2 | Memory organisation code |
| ce1_n_i | input | 1 | Enable input 1, active low |
| ce2_n_i | input | 1 | Enable input 2, active low |
| a_or_ce3_i | input | 1 | Address A, or enable input 3 in code 0 |
| b_or_ce4_i | input | 1 | Address B, or enable input 4 in code 0 |
| ce_n_o | output | 4 | Memory chip enables, active low |

## Verification
Each organisation code is tried with all four address combinations and with both enables toggling. This separates a wrong pair or decode selection from a wrong pass-through. Power failure is raised with some enables low and some high. This shows whether in-flight accesses are held while new ones are blocked. The held enable is then released either by its request rising or by tick expiry, and a request that falls again afterwards shows that a released output does not re-arm. Random stretches also toggle the organisation code, the release flag and the failure flag at arbitrary cycles. This shows that the code is captured only on reset and on a failure-flag fall.

// File: rtl/wp_ce_pkg.sv
// Package: shared types for the delayed write-protect chip-enable gate.
// Assumes four memory channels; the channel count is fixed by the pin set.
package wp_ce_pkg;
    localparam int NUM_CH = 4;

    // Organisation codes; code 3 is treated like ORG_WIDE.
    localparam logic [1:0] ORG_SPLIT = 2'd0;
    localparam logic [1:0] ORG_PAIR  = 2'd1;
    localparam logic [1:0] ORG_WIDE  = 2'd2;

    typedef enum logic [1:0] {
        CH_PASS  = 2'd0,
        CH_HOLD  = 2'd1,
        CH_BLOCK = 2'd2
    } ch_state_t;
endpackage

// File: rtl/wp_ce_router.sv
// Module: wp_ce_router
// Maps the enable and address pins onto four active-low requests
// according to the latched organisation code. Purely combinational.
// Assumes org_i is stable apart from the capture instants.
module wp_ce_router
    import wp_ce_pkg::*;
(
    input  logic [1:0]        org_i,
    input  logic              ce1_n_i,
    input  logic              ce2_n_i,
    input  logic              a_or_ce3_i,
    input  logic              b_or_ce4_i,
    output logic [NUM_CH-1:0] req_n_o
);
    logic [1:0] sel;
    assign sel = {b_or_ce4_i, a_or_ce3_i};

    // Select the routing for the current organisation.
    always_comb begin
        req_n_o = '1;
        case (org_i)
            ORG_SPLIT: req_n_o = {b_or_ce4_i, a_or_ce3_i, ce2_n_i, ce1_n_i};
            ORG_PAIR:  req_n_o = {ce2_n_i | ~a_or_ce3_i, ce2_n_i | a_or_ce3_i,
                                  ce1_n_i | ~a_or_ce3_i, ce1_n_i | a_or_ce3_i};
            default: begin
                for (int k = 0; k < NUM_CH; k++) begin
                    req_n_o[k] = ce1_n_i | (sel != 2'(k));
                end
            end
        endcase
    end
endmodule

// File: rtl/wp_ce_channel.sv
// Module: wp_ce_channel
// One output channel. Passes its request while unprotected. When
// protection begins, an already-active access is held low until its
// request rises or LIMIT millisecond ticks elapse. After that the
// output is blocked high until protection ends. The output is registered.
// Assumes tick_i is a single-cycle pulse.
module wp_ce_channel
    import wp_ce_pkg::*;
#(
    parameter int LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_i,
    input  logic tick_i,
    input  logic req_n_i,
    output logic ce_n_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    ch_state_t      st_q;
    logic [CW-1:0]  cnt_q;
    logic           ce_q;

    assign ce_n_o = ce_q;

    // Channel state machine with hold timer and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_BLOCK;
            cnt_q <= '0;
            ce_q  <= 1'b1;
        end else begin
            case (st_q)
                CH_PASS: begin
                    if (prot_i) begin
                        if (!ce_q && !req_n_i) begin
                            st_q  <= CH_HOLD;
                            cnt_q <= '0;
                            ce_q  <= 1'b0;
                        end else begin
                            st_q <= CH_BLOCK;
                            ce_q <= 1'b1;
                        end
                    end else begin
                        ce_q <= req_n_i;
                    end
                end
                CH_HOLD: begin
                    if (req_n_i || (tick_i && cnt_q == LIM_M1)) begin
                        st_q <= CH_BLOCK;
                        ce_q <= 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (!prot_i) begin
                        st_q <= CH_PASS;
                        ce_q <= req_n_i;
                    end else begin
                        ce_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // An inactive output never turns active under protection.
    assert_block_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_i && ce_q) |=> ce_q);

    // A held access keeps its enable while its request stays low.
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_HOLD && !req_n_i && !(tick_i && cnt_q == LIM_M1)) |=> !ce_q);

    // A held access that ends releases its output high.
    assert_release_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_HOLD && req_n_i) |=> ce_q);

    // The hold timer never passes its limit.
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_M1);
endmodule

// File: rtl/wp_ce_gate.sv
// Module: wp_ce_gate (top)
// Delayed write-protect gate for four backed-up memories. It latches
// the organisation code, routes the enables, and runs one protection
// channel per output. Protection is active while the supply has failed
// or the supervisor has not yet released write access.
// Assumes pwr_fail_i and wp_release_i are already synchronous to clk.
module wp_ce_gate
    import wp_ce_pkg::*;
#(
    parameter int LIMIT = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail_i,
    input  logic              wp_release_i,
    input  logic              tick_ms_i,
    input  logic [1:0]        mode_i,
    input  logic              ce1_n_i,
    input  logic              ce2_n_i,
    input  logic              a_or_ce3_i,
    input  logic              b_or_ce4_i,
    output logic [NUM_CH-1:0] ce_n_o
);
    logic [1:0]        org_q;
    logic              pf_q;
    logic              prot;
    logic [NUM_CH-1:0] req_n;

    assign prot = pwr_fail_i | ~wp_release_i;

    // Capture the organisation code at reset and when the supply returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            org_q <= mode_i;
            pf_q  <= 1'b1;
        end else begin
            pf_q <= pwr_fail_i;
            if (pf_q && !pwr_fail_i) begin
                org_q <= mode_i;
            end
        end
    end

    wp_ce_router u_router (
        .org_i      (org_q),
        .ce1_n_i    (ce1_n_i),
        .ce2_n_i    (ce2_n_i),
        .a_or_ce3_i (a_or_ce3_i),
        .b_or_ce4_i (b_or_ce4_i),
        .req_n_o    (req_n)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wp_ce_channel #(.LIMIT(LIMIT)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .prot_i  (prot),
            .tick_i  (tick_ms_i),
            .req_n_i (req_n[g]),
            .ce_n_o  (ce_n_o[g])
        );
    end

    // The code moves only when the failure flag falls.
    assert_org_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_q && !pwr_fail_i) |=> $stable(org_q));
endmodule

// File: tb/wp_ce_gate_tb.sv
module wp_ce_gate_tb;
    localparam int LIM = 5;

    logic       clk = 1'b0;
    logic       rst_n, pwr_fail, release_i, tick;
    logic [1:0] mode;
    logic       ce1, ce2, pa, pb;
    logic [3:0] ce_n;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state: 0 pass, 1 hold, 2 block.
    logic [1:0] m_org;
    logic       m_pf;
    int         m_st  [4];
    int         m_cnt [4];
    logic [3:0] m_out;

    always #2 clk = ~clk;

    wp_ce_gate #(.LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .wp_release_i(release_i),
        .tick_ms_i(tick), .mode_i(mode), .ce1_n_i(ce1), .ce2_n_i(ce2),
        .a_or_ce3_i(pa), .b_or_ce4_i(pb), .ce_n_o(ce_n)
    );

    function automatic logic [3:0] route(input logic [1:0] org, input logic c1,
                                         input logic c2, input logic a, input logic b);
        logic [3:0] r;
        r = 4'b1111;
        if (org == 2'd0) begin
            r = {b, a, c2, c1};
        end else if (org == 2'd1) begin
            if (!c1) r[a ? 1 : 0] = 1'b0;
            if (!c2) r[a ? 3 : 2] = 1'b0;
        end else begin
            if (!c1) r[{b, a}] = 1'b0;
        end
        return r;
    endfunction

    task automatic model_edge();
        logic [3:0] rq;
        logic       pr;
        if (!rst_n) begin
            m_org = mode;
            m_pf  = 1'b1;
            m_out = 4'b1111;
            for (int k = 0; k < 4; k++) begin m_st[k] = 2; m_cnt[k] = 0; end
        end else begin
            rq = route(m_org, ce1, ce2, pa, pb);
            pr = pwr_fail || !release_i;
            for (int k = 0; k < 4; k++) begin
                if (m_st[k] == 0) begin
                    if (pr) begin
                        if (!m_out[k] && !rq[k]) begin m_st[k] = 1; m_cnt[k] = 0; end
                        else begin m_st[k] = 2; m_out[k] = 1'b1; end
                    end else m_out[k] = rq[k];
                end else if (m_st[k] == 1) begin
                    if (rq[k] || (tick && m_cnt[k] == LIM - 1)) begin
                        m_st[k] = 2; m_out[k] = 1'b1;
                    end else if (tick) m_cnt[k]++;
                end else begin
                    if (!pr) begin m_st[k] = 0; m_out[k] = rq[k]; end
                end
            end
            if (m_pf && !pwr_fail) m_org = mode;
            m_pf = pwr_fail;
        end
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        n_chk++;
        if (ce_n !== exp) begin
            n_err++;
            $display("FAIL %s: ce_n_o=%b expected=%b at %0t", tag, ce_n, exp, $time);
        end
    endtask

    // One clock; model follows the edge; compare away from the edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, m_out);
    endtask

    task automatic set_ce(input logic c1, input logic c2, input logic a, input logic b);
        ce1 = c1; ce2 = c2; pa = a; pb = b;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; pwr_fail = 1'b1; release_i = 1'b0; tick = 1'b0; mode = 2'd0;
        set_ce(1'b0, 1'b0, 1'b0, 1'b0);
        // R1: reset holds every output inactive.
        repeat (3) step("R1");
        chk("R1 fixed", 4'b1111);
        rst_n = 1'b1;
        step("R1 after reset");
        chk("R1 fixed after reset", 4'b1111);
        pwr_fail = 1'b0;
        step("R6 recovery");
        chk("R6 recovery fixed", 4'b1111);
        // R2, R3: pass-through in organisation code 0.
        release_i = 1'b1;
        set_ce(1'b0, 1'b1, 1'b1, 1'b1);
        step("R2 R3");
        chk("R3 fixed", 4'b1110);
        set_ce(1'b1, 1'b1, 1'b0, 1'b1);
        step("R3 ce3");
        chk("R3 ce3 fixed", 4'b1011);
        // R10: code change without a failure-flag fall is ignored.
        mode = 2'd2;
        set_ce(1'b0, 1'b1, 1'b1, 1'b1);
        step("R10 ignore");
        chk("R10 ignore fixed", 4'b1110);
        // R7 and R9: hold under failure, then timeout.
        pwr_fail = 1'b1;
        step("R7 hold");
        chk("R7 hold fixed", 4'b1110);
        tick = 1'b1;
        repeat (LIM - 1) step("R7 counting");
        chk("R7 before limit", 4'b1110);
        step("R9 timeout");
        chk("R9 timeout fixed", 4'b1111);
        tick = 1'b0;
        // R10: capture code 1 on the fall, keep outputs blocked until release.
        release_i = 1'b0; mode = 2'd1;
        step("R6 release low");
        pwr_fail = 1'b0;
        step("R10 capture");
        chk("R6 still blocked", 4'b1111);
        mode = 2'd0;
        release_i = 1'b1;
        set_ce(1'b0, 1'b1, 1'b1, 1'b0);
        step("R4 pair");
        chk("R4 upper of pair 0", 4'b1101);
        set_ce(1'b1, 1'b0, 1'b0, 1'b0);
        step("R4 pair b");
        chk("R4 lower of pair 1", 4'b1011);
        // R8: request rises during a hold, then falls again: stays high.
        pwr_fail = 1'b1;
        step("R7 pair hold");
        chk("R7 pair hold fixed", 4'b1011);
        ce2 = 1'b1;
        step("R8 end");
        chk("R8 end fixed", 4'b1111);
        ce2 = 1'b0;
        step("R8 refall");
        chk("R8 refall fixed", 4'b1111);
        // R5: capture code 2 (then 3) and walk the decode.
        mode = 2'd2; pwr_fail = 1'b0;
        step("R10 code2");
        for (int s = 0; s < 4; s++) begin
            set_ce(1'b0, 1'b1, s[0], s[1]);
            step("R5 decode");
            chk("R5 decode fixed", ~(4'b0001 << s));
        end
        pwr_fail = 1'b1; ce1 = 1'b1;
        step("R6 fail");
        mode = 2'd3; pwr_fail = 1'b0;
        step("R10 code3");
        set_ce(1'b0, 1'b1, 1'b0, 1'b1);
        step("R5 code3");
        chk("R5 code3 fixed", 4'b1011);
        // Random stretch checked against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            string tag;
            if (($urandom % 16) == 0) pwr_fail = ~pwr_fail;
            if (($urandom % 8) == 0) release_i = ~release_i;
            tick = (($urandom % 3) == 0);
            mode = 2'($urandom);
            if (($urandom % 4) == 0) set_ce(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (m_st[0] == 1 || m_st[1] == 1 || m_st[2] == 1 || m_st[3] == 1) tag = "R7 R8 R9";
            else if (pwr_fail || !release_i) tag = "R6";
            else if (m_org == 2'd0) tag = "R2 R3";
            else if (m_org == 2'd1) tag = "R2 R4";
            else tag = "R2 R5";
            step(tag);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule